// File: doc/BRIEF.md
# SDRAM Read-Burst Command Scheduler

This block sits on the controller side of a single-data-rate SDRAM. It takes one request at a time through a ready/valid handshake and turns it into registered command, bank, address and data-mask pins. A read request can ask for fewer beats than the configured burst. In that case the scheduler cuts the burst short with a bank precharge. The precharge goes out CAS latency minus one cycles before the edge that carries the last wanted beat, so it always lands `len` cycles after the READ, whatever the latency.

A write that arrives while read data is still coming back is held for a configurable number of turnaround NOP cycles, plus one extra when the clock is too fast to avoid contention. During those cycles the mask pin is raised so that the device releases the data bus. The mask is dropped again in the WRITE cycle itself, because the mask acts on write data with no latency. After a precharge, a per-bank timer keeps the handshake closed for that bank until the row-precharge time has passed.

Top module: `rdburst_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, the command pins carry NOP (4'b0111) and `dqm_o` is high. `req_ready_o` is high once reset is released.
- R2: An accepted read drives READ (4'b0101) in the next cycle. `ba_o` carries the request bank, the column sits in the low bits of `addr_o`, and `addr_o[10]` equals `cfg_ap_i`.
- R3: Burst codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 beats, and code 7 means full page. When `cfg_ap_i` is low and `req_len_i` is non-zero, a read is truncated if the code is 7 or if `req_len_i` is below the burst length. A truncated read gets PRECHARGE (4'b0010) exactly `req_len_i` cycles after its READ, to the same bank, with `addr_o[10]` low.
- R4: No PRECHARGE is issued for a read whose `cfg_ap_i` is high, whose `req_len_i` is zero, or whose `req_len_i` is not below a fixed burst length.
- R5: `req_ready_o` stays low from the READ cycle of a truncated read until its PRECHARGE cycle.
- R6: After a PRECHARGE in cycle p, `req_ready_o` is low for that bank through cycle p+`cfg_trp_i`-2, so the next command to it lands no earlier than p+`cfg_trp_i`. Other banks are not blocked.
- R7: A write accepted while read data is still outstanding is issued after g = `cfg_nop_i` + `cfg_extra_nop_i` NOP cycles, that is g+1 cycles after acceptance. Read data counts as outstanding up to CL+beats-1 cycles after the READ, or indefinitely for an untruncated full-page read. When g is zero the WRITE follows at once.
- R8: During those turnaround NOPs `dqm_o` is high unless the burst code is 0 (one beat), in which case it stays low. In the WRITE (4'b0100) cycle `dqm_o` is low.
- R9: A write accepted with no read data outstanding drives WRITE in the next cycle with `dqm_o` low, regardless of `cfg_nop_i`.
- R10: `req_ready_o` is low during the turnaround NOP cycles.
- R11: `dqm_o` is low in the READ cycle and stays low while the read burst runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | 2 | Target bank |
| req_col_i | input | 9 | Start column |
| req_len_i | input | 9 | Wanted read beats, 0 = whole burst |
| cfg_cl_i | input | 2 | CAS latency, 1 to 3 |
| cfg_bl_i | input | 3 | Burst code: 0..3 = 1/2/4/8 beats, 7 = full page |
| cfg_ap_i | input | 1 | Auto-precharge flag placed on address bit 10 |
| cfg_trp_i | input | 4 | Row-precharge time in cycles, at least 1 |
| cfg_nop_i | input | 3 | Read-to-write turnaround NOPs |
| cfg_extra_nop_i | input | 1 | One more turnaround NOP for short clock periods |
| cmd_o | output | 4 | Chip select, row strobe, column strobe, write enable |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Address bus |
| dqm_o | output | 1 | Data mask |

## Verification
Each result is counted from the cycle in which the READ appears, one cycle after the handshake edge. That cycle is numbered 0. A truncating PRECHARGE is due in cycle `len`. Ready for the precharged bank comes back in cycle `len`+`trp`-1. A write presented in cycle 0 shows up as WRITE in cycle g+1, and an idle write appears one cycle after its handshake. The bench applies each request at a falling edge, then samples the pins at every later falling edge. It compares each cycle index against these formulas over sweeps of latency, burst code, length, auto-precharge and gap.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [3:0] {
    CMD_NOP = 4'b0111,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010
  } cmd_e;

  localparam logic [2:0] BL_CODE_FULL = 3'd7;

  // beats of a fixed burst; the full-page code is handled separately
  function automatic logic [3:0] burst_beats(input logic [2:0] code);
    case (code)
      3'd0:    burst_beats = 4'd1;
      3'd1:    burst_beats = 4'd2;
      3'd2:    burst_beats = 4'd4;
      default: burst_beats = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/rbs_bank_timer.sv
module rbs_bank_timer #(
  parameter int NUM_BANKS = 4,
  parameter int TRP_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [TRP_W-1:0]     trp_i,
  output logic [NUM_BANKS-1:0] busy_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [TRP_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cnt_q <= '0;
      else if (load_i && bank_i == BANK_W'(b))
        cnt_q <= (trp_i == '0) ? '0 : trp_i - 1'b1;
      else if (cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
    assign busy_o[b] = (cnt_q != '0);
  end
endmodule

// File: rtl/rbs_burst_track.sv
module rbs_burst_track
  import rbs_pkg::*;
#(
  parameter int LEN_W   = 9,
  localparam int TAIL_W = LEN_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       cl_i,
  input  logic [2:0]       bl_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             ap_i,
  output logic             pre_fire_o,
  output logic             pre_pend_o,
  output logic             tail_live_o
);
  logic [LEN_W-1:0]  pre_q;
  logic [TAIL_W-1:0] tail_q;
  logic              open_q;
  logic [3:0]        beats;
  logic              full_page, trunc;
  logic [TAIL_W-1:0] tail_load;

  always_comb begin
    beats     = burst_beats(bl_i);
    full_page = (bl_i == BL_CODE_FULL);
    trunc     = !ap_i && (len_i != '0) &&
                (full_page || (TAIL_W'(len_i) < TAIL_W'(beats)));
    // cycles from the READ to the last wanted beat
    tail_load = TAIL_W'(cl_i) + (trunc ? TAIL_W'(len_i) : TAIL_W'(beats)) - TAIL_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tail_q <= '0;
      open_q <= 1'b0;
    end else if (start_i) begin
      pre_q  <= trunc ? len_i : '0;
      tail_q <= tail_load;
      open_q <= full_page && !trunc;
    end else if (stop_i) begin
      pre_q  <= '0;
      tail_q <= '0;
      open_q <= 1'b0;
    end else begin
      if (pre_q != '0)  pre_q  <= pre_q - 1'b1;
      if (tail_q != '0) tail_q <= tail_q - 1'b1;
    end
  end

  assign pre_fire_o  = (pre_q == LEN_W'(1));
  assign pre_pend_o  = (pre_q != '0);
  assign tail_live_o = (tail_q != '0) || open_q;
endmodule

// File: rtl/rbs_turnaround.sv
module rbs_turnaround #(
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= gap_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign fire_o = (cnt_q == GAP_W'(1));
endmodule

// File: rtl/rdburst_sched.sv
module rdburst_sched
  import rbs_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 12,
  parameter int AP_BIT    = 10,
  parameter int LEN_W     = 9,
  parameter int TRP_W     = 4,
  parameter int NOP_W     = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int GAP_W    = NOP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [1:0]        cfg_cl_i,
  input  logic [2:0]        cfg_bl_i,
  input  logic              cfg_ap_i,
  input  logic [TRP_W-1:0]  cfg_trp_i,
  input  logic [NOP_W-1:0]  cfg_nop_i,
  input  logic              cfg_extra_nop_i,
  output logic [3:0]        cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dqm_o
);
  logic [NUM_BANKS-1:0] bank_busy;
  logic pre_fire, pre_pend, tail_live, turn_busy, turn_fire;
  logic acc, acc_rd, acc_wr, wr_now, wr_turn;
  logic [GAP_W-1:0] gap;

  logic [BANK_W-1:0] rd_bank_q, wr_bank_q;
  logic [COL_W-1:0]  wr_col_q;

  cmd_e              cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dqm_q, dqm_d;

  assign gap         = GAP_W'(cfg_nop_i) + GAP_W'(cfg_extra_nop_i);
  assign req_ready_o = !turn_busy && !pre_pend && !bank_busy[req_bank_i];
  assign acc         = req_valid_i && req_ready_o;
  assign acc_rd      = acc && !req_write_i;
  assign acc_wr      = acc && req_write_i;
  assign wr_now      = acc_wr && (!tail_live || gap == '0);
  assign wr_turn     = acc_wr && tail_live && (gap != '0);

  rbs_burst_track #(.LEN_W(LEN_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (acc_rd),
    .stop_i      (acc_wr),
    .cl_i        (cfg_cl_i),
    .bl_i        (cfg_bl_i),
    .len_i       (req_len_i),
    .ap_i        (cfg_ap_i),
    .pre_fire_o  (pre_fire),
    .pre_pend_o  (pre_pend),
    .tail_live_o (tail_live)
  );

  rbs_turnaround #(.GAP_W(GAP_W)) u_turn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wr_turn),
    .gap_i   (gap),
    .busy_o  (turn_busy),
    .fire_o  (turn_fire)
  );

  rbs_bank_timer #(.NUM_BANKS(NUM_BANKS), .TRP_W(TRP_W)) u_banks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pre_fire),
    .bank_i (rd_bank_q),
    .trp_i  (cfg_trp_i),
    .busy_o (bank_busy)
  );

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    dqm_d  = dqm_q;
    if (acc_rd) begin
      cmd_d          = CMD_RD;
      ba_d           = req_bank_i;
      addr_d         = ADDR_W'(req_col_i);
      addr_d[AP_BIT] = cfg_ap_i;
      dqm_d          = 1'b0;
    end else if (wr_now) begin
      cmd_d          = CMD_WR;
      ba_d           = req_bank_i;
      addr_d         = ADDR_W'(req_col_i);
      addr_d[AP_BIT] = cfg_ap_i;
      dqm_d          = 1'b0;
    end else if (wr_turn) begin
      // mask the device output while it releases the bus; not needed for single beats
      dqm_d = (cfg_bl_i != 3'd0);
    end else if (turn_fire) begin
      cmd_d          = CMD_WR;
      ba_d           = wr_bank_q;
      addr_d         = ADDR_W'(wr_col_q);
      addr_d[AP_BIT] = cfg_ap_i;
      dqm_d          = 1'b0;
    end else if (pre_fire) begin
      cmd_d = CMD_PRE;
      ba_d  = rd_bank_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= CMD_NOP;
      ba_q      <= '0;
      addr_q    <= '0;
      dqm_q     <= 1'b1;
      rd_bank_q <= '0;
      wr_bank_q <= '0;
      wr_col_q  <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      dqm_q  <= dqm_d;
      if (acc_rd) rd_bank_q <= req_bank_i;
      if (wr_turn) begin
        wr_bank_q <= req_bank_i;
        wr_col_q  <= req_col_i;
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign ba_o   = ba_q;
  assign addr_o = addr_q;
  assign dqm_o  = dqm_q;
endmodule

// File: rtl/rbs_chk.sv
module rbs_chk #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 9,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int TRP_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic [COL_W-1:0]  req_col_i,
  input logic [TRP_W-1:0]  cfg_trp_i,
  input logic [3:0]        cmd_o,
  input logic [BANK_W-1:0] ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              dqm_o
);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (cmd_o == 4'b0111) && dqm_o);

  // R2
  read_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !req_write_i |=>
      (cmd_o == 4'b0101) && (ba_o == $past(req_bank_i)) &&
      (addr_o[COL_W-1:0] == $past(req_col_i)));

  // R3
  pre_single_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0010) |-> !addr_o[AP_BIT]);

  // R6
  pre_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0010) && req_valid_i && req_ready_o && (req_bank_i == ba_o) |->
      (cfg_trp_i <= TRP_W'(1)));

  // R8
  write_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0100) |-> !dqm_o);

  // R11
  read_unmasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 4'b0101) |-> !dqm_o);
endmodule

bind rdburst_sched rbs_chk #(
  .BANK_W (BANK_W),
  .COL_W  (COL_W),
  .ADDR_W (ADDR_W),
  .AP_BIT (AP_BIT),
  .TRP_W  (TRP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_write_i (req_write_i),
  .req_bank_i  (req_bank_i),
  .req_col_i   (req_col_i),
  .cfg_trp_i   (cfg_trp_i),
  .cmd_o       (cmd_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .dqm_o       (dqm_o)
);

// File: tb/sim_rdburst_sched.sv
module sim_rdburst_sched;
  localparam int NOP = 4'b0111, RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic       req_ready;
  logic [1:0] req_bank = '0;
  logic [8:0] req_col = '0, req_len = '0;
  logic [1:0] cfg_cl = 2'd1;
  logic [2:0] cfg_bl = '0;
  logic       cfg_ap = 1'b0;
  logic [3:0] cfg_trp = 4'd1;
  logic [2:0] cfg_nop = '0;
  logic       cfg_extra = 1'b0;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [11:0] addr;
  logic       dqm;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rdburst_sched u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bank_i(req_bank), .req_col_i(req_col), .req_len_i(req_len),
    .cfg_cl_i(cfg_cl), .cfg_bl_i(cfg_bl), .cfg_ap_i(cfg_ap), .cfg_trp_i(cfg_trp),
    .cfg_nop_i(cfg_nop), .cfg_extra_nop_i(cfg_extra),
    .cmd_o(cmd), .ba_o(ba), .addr_o(addr), .dqm_o(dqm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int pins(input int c, input int b, input int a);
    return (c << 16) | (b << 12) | a;
  endfunction

  task automatic do_reset();
    req_valid = 1'b0;
    req_write = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // read sweep point: covers R2 R3 R4 R5 R6 R11
  task automatic run_read(input int cl, input int blc, input int len, input int ap, input int trp);
    int beats, bank, col, exp_c, exp_a;
    bit trunc, fp, pend, waitb, exp_rdy;
    do_reset();
    bank = (cl + blc) % 4;
    col  = 17 * len + 3 * blc + cl;
    cfg_cl = 2'(cl); cfg_bl = 3'(blc); cfg_ap = ap[0]; cfg_trp = 4'(trp);
    cfg_nop = 3'd2; cfg_extra = 1'b0;
    req_write = 1'b0; req_bank = 2'(bank); req_col = 9'(col); req_len = 9'(len);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    fp    = (blc == 7);
    beats = fp ? 256 : (1 << blc);
    trunc = (ap == 0) && (len != 0) && (fp || len < beats);
    for (int c = 0; c < 14; c++) begin
      // even cycles probe the read bank, odd cycles another bank
      req_bank = (c % 2 == 0) ? 2'(bank) : 2'(bank ^ 1);
      #0;
      pend  = trunc && (c < len);
      waitb = trunc && (c >= len) && (c - len < trp - 1) && (c % 2 == 0);
      exp_rdy = !pend && !waitb;
      if (c == 0) begin
        exp_c = RD; exp_a = col | (ap << 10);
        chk(pins(cmd, ba, addr) == pins(exp_c, bank, exp_a), "R2 read pins", pins(cmd, ba, addr), pins(exp_c, bank, exp_a));
      end else if (trunc && c == len) begin
        chk(pins(cmd, ba, addr) == pins(PRE, bank, 0), "R3 early precharge", pins(cmd, ba, addr), pins(PRE, bank, 0));
      end else begin
        chk(cmd == 4'(NOP), trunc ? "R3 nop outside precharge slot" : "R4 no precharge", int'(cmd), NOP);
      end
      chk(dqm == 1'b0, "R11 dqm low during read", int'(dqm), 0);
      chk(req_ready == exp_rdy, pend ? "R5 ready while precharge pending" : "R6 ready vs bank wait",
          int'(req_ready), int'(exp_rdy));
      @(negedge clk);
    end
  endtask

  // read then write presented in the READ cycle: covers R7 R8 R10
  task automatic run_rw(input int blc, input int nop, input int extra);
    int g;
    do_reset();
    cfg_cl = 2'd3; cfg_bl = 3'(blc); cfg_ap = 1'b0; cfg_trp = 4'd2;
    cfg_nop = 3'(nop); cfg_extra = extra[0];
    req_write = 1'b0; req_bank = 2'd0; req_col = 9'd5; req_len = '0;
    req_valid = 1'b1;
    @(negedge clk);                        // cycle 0: READ
    req_write = 1'b1; req_bank = 2'd2; req_col = 9'd9;
    #0;
    chk(req_ready == 1'b1, "R7 write accepted in read cycle", int'(req_ready), 1);
    @(negedge clk);                        // cycle 1
    req_valid = 1'b0;
    g = nop + extra;
    for (int c = 1; c <= g + 2; c++) begin
      if (c <= g) begin
        chk(cmd == 4'(NOP), "R7 turnaround nop", int'(cmd), NOP);
        chk(dqm == (blc != 0), "R8 dqm in turnaround", int'(dqm), int'(blc != 0));
        chk(req_ready == 1'b0, "R10 ready low in turnaround", int'(req_ready), 0);
      end else if (c == g + 1) begin
        chk(pins(cmd, ba, addr) == pins(WR, 2, 9), "R7 write slot", pins(cmd, ba, addr), pins(WR, 2, 9));
        chk(dqm == 1'b0, "R8 dqm low on write", int'(dqm), 0);
      end else begin
        chk(cmd == 4'(NOP), "R7 single write", int'(cmd), NOP);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int blcodes[5] = '{0, 1, 2, 3, 7};
    rst_n = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cmd == 4'(NOP), "R1 reset cmd", int'(cmd), NOP);
    chk(dqm == 1'b1, "R1 reset dqm", int'(dqm), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd == 4'(NOP) && dqm, "R1 after release", pins(cmd, 0, dqm), pins(NOP, 0, 1));
    chk(req_ready == 1'b1, "R1 ready after release", int'(req_ready), 1);

    for (int cl = 1; cl <= 3; cl++)
      for (int bi = 0; bi < 5; bi++)
        for (int len = 0; len <= 3; len++)
          for (int ap = 0; ap <= 1; ap++)
            run_read(cl, blcodes[bi], len, ap, 1 + (cl + bi + len) % 4);

    for (int bi = 0; bi < 3; bi++)
      for (int nop = 0; nop <= 3; nop++)
        for (int ex = 0; ex <= 1; ex++)
          run_rw(blcodes[bi], nop, ex);

    // R9 write from idle
    do_reset();
    cfg_nop = 3'd3; cfg_bl = 3'd2;
    req_write = 1'b1; req_bank = 2'd1; req_col = 9'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(pins(cmd, ba, addr) == pins(WR, 1, 3), "R9 idle write", pins(cmd, ba, addr), pins(WR, 1, 3));
    chk(dqm == 1'b0, "R9 idle write dqm", int'(dqm), 0);

    // R9 write after short read tail ended (CL1, one beat: data done by cycle 0)
    do_reset();
    cfg_cl = 2'd1; cfg_bl = 3'd0; cfg_nop = 3'd3; cfg_ap = 1'b0;
    req_write = 1'b0; req_bank = 2'd0; req_col = 9'd1; req_len = '0; req_valid = 1'b1;
    @(negedge clk);                        // cycle 0
    req_valid = 1'b0;
    @(negedge clk);                        // cycle 1
    req_write = 1'b1; req_bank = 2'd3; req_col = 9'd7; req_valid = 1'b1;
    @(negedge clk);                        // cycle 2
    req_valid = 1'b0;
    chk(pins(cmd, ba, addr) == pins(WR, 3, 7), "R9 write after tail", pins(cmd, ba, addr), pins(WR, 3, 7));

    // R7 untruncated full page keeps read data outstanding
    do_reset();
    cfg_cl = 2'd2; cfg_bl = 3'd7; cfg_nop = 3'd1; cfg_extra = 1'b1;
    req_write = 1'b0; req_bank = 2'd1; req_col = 9'd0; req_len = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    req_write = 1'b1; req_bank = 2'd1; req_col = 9'd4; req_valid = 1'b1;
    @(negedge clk);                        // acceptance + 1: first NOP
    req_valid = 1'b0;
    chk(cmd == 4'(NOP) && dqm, "R7 full-page turnaround", pins(cmd, 0, dqm), pins(NOP, 0, 1));
    @(negedge clk);
    chk(cmd == 4'(NOP), "R7 full-page second nop", int'(cmd), NOP);
    @(negedge clk);
    chk(pins(cmd, ba, addr) == pins(WR, 1, 4), "R7 full-page write", pins(cmd, ba, addr), pins(WR, 1, 4));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule